// File: doc/BRIEF.md
# Addressed Peripheral Device Control Unit

This block is the device end of a processor I/O bus built from four groups of wires: a device-selector bus, a command bus, a data path and one available-status line. The unit compares the selector bus with its own fixed device code. While that code is present, the unit accepts commands, accepts writes into its I/O data register, and drives its return path. On the device side, a start pulse and a done input stand in for the mechanical device. The direction and the write data are held steady for the device while an operation runs.

The processor uses the block in a fixed order. It selects the device, asks for status and reads it, connects the device, and checks that the status shows ready. It then starts a read or a write and waits for the available line to rise before it moves the next data unit. It repeats this until the message ends. The available line falls when an operation starts and rises when the device reports completion. Every byte received from the device is checked for even parity, and a mismatch is reported in the status code. Status and data come back over one shared return path. The STATUS_REQUEST command picks status for that path, and an accepted start picks the data register again.

Top module: `io_devctl`

## Requirements
- R1: The unit is selected only when `sel_bus` equals `DEV_CODE` exactly. While it is not selected, commands and data writes have no effect and `rdata` is zero.
- R2: After reset, `avail` is 1, `dev_start` is 0, the data register is 0, the return path shows data, and the stored status is disconnected (code 2).
- R3: Command codes on `cmd` (taken only when `cmd_valid` is 1 and the unit is selected) are: 1 CONNECT, 2 DISCONNECT, 3 START_READ, 4 START_WRITE and 5 STATUS_REQUEST. Codes 0, 6 and 7 do nothing. CONNECT sets status ready (code 0) when the unit is not busy. DISCONNECT sets status disconnected (code 2) at any time and ends any operation in progress.
- R4: A start command that is accepted while the unit is connected and not busy has these effects, all visible one cycle later: `avail` goes to 0, `dev_start` pulses high for exactly one cycle, and the status becomes busy (code 1). A start command is ignored while the unit is disconnected or busy.
- R5: `dev_done` while the unit is busy has these effects one cycle later: `avail` returns to 1 and the status becomes completed (code 4). For a read, `dev_rdata` is captured into the data register. `dev_done` has no effect while the unit is idle.
- R6: On read completion, the nine bits `{dev_rdata, dev_rpar}` must contain an even number of ones. If they do not, the status becomes parity error (code 5), and the byte is still captured.
- R7: A data write (`wr_en`) while the unit is busy is ignored. The data register and the status are left unchanged.
- R8: While `dev_power` is 0, the reported status is power-off (code 3). The unit drops its connection, ends any operation and holds `avail` at 1. When power returns, the status reads disconnected (code 2).
- R9: `rdata` shows the 3-bit status code, zero-extended, after STATUS_REQUEST. It shows the data register after reset and after each accepted start.
- R10: `dev_wdata` always presents the data register. `dev_dir` reads 1 for a write operation and 0 for a read operation for as long as the operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_bus | input | SEL_W | Device-selector bus |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Command opcode |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | DATA_W | Data from the processor |
| rdata | output | DATA_W | Shared return path (status or data) |
| avail | output | 1 | Available-status line |
| dev_power | input | 1 | Device power present |
| dev_done | input | 1 | Device reports completion |
| dev_rdata | input | DATA_W | Byte received from the device |
| dev_rpar | input | 1 | Even-parity bit of the received byte |
| dev_start | output | 1 | One-cycle start pulse to the device |
| dev_dir | output | 1 | Operation direction, 1 for write |
| dev_wdata | output | DATA_W | Data register toward the device |

## Verification
The hardest situations to reach are the ones where several events land in the same cycle. One is a completion that arrives together with a power loss. Another is a completion that arrives together with a DISCONNECT. A third is a data write that arrives while the unit is busy. Each of these needs the unit to be connected, selected and busy at that exact moment. Directed sequences first walk the bus through connect, start, write and read completions with good and bad parity, then through a power loss in the middle of an operation. A long run of seeded random cycles follows, with most cycles on the unit's own code and frequent done pulses. That run makes these collisions happen many times, and a bench model computed from the requirements checks every cycle.

// File: rtl/io_devctl_pkg.sv
package io_devctl_pkg;

  typedef enum logic [2:0] {
    ST_READY  = 3'd0,
    ST_BUSY   = 3'd1,
    ST_DISC   = 3'd2,
    ST_PWROFF = 3'd3,
    ST_DONE   = 3'd4,
    ST_PARERR = 3'd5
  } dev_status_e;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_CONNECT  = 3'd1,
    OP_DISCONN  = 3'd2,
    OP_START_RD = 3'd3,
    OP_START_WR = 3'd4,
    OP_STAT_REQ = 3'd5
  } dev_op_e;

  typedef struct packed {
    logic connect;
    logic disconnect;
    logic start_rd;
    logic start_wr;
    logic stat_req;
  } cmd_strobe_t;

endpackage

// File: rtl/io_sel_decode.sv
module io_sel_decode #(
  parameter int                 SEL_W    = 6,
  parameter logic [SEL_W-1:0]   DEV_CODE = 6'h2B
) (
  input  logic [SEL_W-1:0] sel_bus,
  output logic             hit
);
  logic [SEL_W-1:0] bit_eq;

  // one equality cell per selector line, then an AND tree
  for (genvar i = 0; i < SEL_W; i++) begin : g_bit
    assign bit_eq[i] = ~(sel_bus[i] ^ DEV_CODE[i]);
  end

  assign hit = &bit_eq;
endmodule

// File: rtl/io_cmd_decode.sv
module io_cmd_decode
  import io_devctl_pkg::*;
(
  input  logic        hit,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd,
  output cmd_strobe_t stb
);
  always_comb begin
    stb = '0;
    if (hit && cmd_valid) begin
      case (cmd)
        OP_CONNECT:  stb.connect    = 1'b1;
        OP_DISCONN:  stb.disconnect = 1'b1;
        OP_START_RD: stb.start_rd   = 1'b1;
        OP_START_WR: stb.start_wr   = 1'b1;
        OP_STAT_REQ: stb.stat_req   = 1'b1;
        default:     stb            = '0;
      endcase
    end
  end
endmodule

// File: rtl/io_parity_check.sv
module io_parity_check #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              bad
);
  // even parity: data and parity bit together carry an even count of ones
  assign bad = ^{data, par};
endmodule

// File: rtl/io_status_ctl.sv
module io_status_ctl
  import io_devctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  cmd_strobe_t stb,
  input  logic        dev_power,
  input  logic        dev_done,
  input  logic        par_bad,
  output logic        connected,
  output logic        busy,
  output logic        avail,
  output logic [2:0]  code,
  output logic        dir_wr,
  output logic        start_pulse,
  output logic        view_status,
  output logic        rd_capture
);
  logic        conn_q, conn_d;
  logic        busy_q, busy_d;
  logic        avail_q, avail_d;
  dev_status_e code_q, code_d;
  logic        dir_q, dir_d;
  logic        start_q, start_d;
  logic        view_q, view_d;
  logic        finish;

  assign finish     = dev_power && !stb.disconnect && busy_q && dev_done;
  assign rd_capture = finish && !dir_q;

  always_comb begin
    conn_d  = conn_q;
    busy_d  = busy_q;
    avail_d = avail_q;
    code_d  = code_q;
    dir_d   = dir_q;
    start_d = 1'b0;
    view_d  = view_q;
    if (stb.stat_req) view_d = 1'b1;
    if (!dev_power || stb.disconnect) begin
      conn_d  = 1'b0;
      busy_d  = 1'b0;
      avail_d = 1'b1;
      code_d  = ST_DISC;
    end else if (busy_q) begin
      if (dev_done) begin
        busy_d  = 1'b0;
        avail_d = 1'b1;
        code_d  = (!dir_q && par_bad) ? ST_PARERR : ST_DONE;
      end
    end else if (stb.connect) begin
      conn_d = 1'b1;
      code_d = ST_READY;
    end else if ((stb.start_rd || stb.start_wr) && conn_q) begin
      busy_d  = 1'b1;
      avail_d = 1'b0;
      code_d  = ST_BUSY;
      dir_d   = stb.start_wr;
      start_d = 1'b1;
      view_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q  <= 1'b0;
      busy_q  <= 1'b0;
      avail_q <= 1'b1;
      code_q  <= ST_DISC;
      dir_q   <= 1'b0;
      start_q <= 1'b0;
      view_q  <= 1'b0;
    end else begin
      conn_q  <= conn_d;
      busy_q  <= busy_d;
      avail_q <= avail_d;
      code_q  <= code_d;
      dir_q   <= dir_d;
      start_q <= start_d;
      view_q  <= view_d;
    end
  end

  assign connected   = conn_q;
  assign busy        = busy_q;
  assign avail       = avail_q;
  assign code        = code_q;
  assign dir_wr      = dir_q;
  assign start_pulse = start_q;
  assign view_status = view_q;

  // R4: the start pulse never lasts two cycles
  a_r4_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R4: the available line stays low for the whole operation
  a_r4_busy_not_avail: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !avail_q);
  // R5: completion frees the unit on the next cycle
  a_r5_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (avail_q && !busy_q));
  // R6: a bad received byte gives the parity-error code
  a_r6_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_capture && par_bad) |=> (code_q == ST_PARERR));
  // R8: loss of power drops the connection and releases the line
  a_r8_power_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_power |=> (!conn_q && avail_q && !busy_q));
endmodule

// File: rtl/io_devctl.sv
module io_devctl
  import io_devctl_pkg::*;
#(
  parameter int               SEL_W    = 6,
  parameter logic [SEL_W-1:0] DEV_CODE = 6'h2B,
  parameter int               DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_bus,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rdata,
  output logic              avail,
  input  logic              dev_power,
  input  logic              dev_done,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic              dev_rpar,
  output logic              dev_start,
  output logic              dev_dir,
  output logic [DATA_W-1:0] dev_wdata
);
  localparam int CODE_W = 3;
  localparam int PAD_W  = DATA_W - CODE_W;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic              hit;
  cmd_strobe_t       stb;
  logic              par_bad;
  logic              connected, busy, view_status, rd_capture;
  logic [CODE_W-1:0] code, shown_code;
  logic [DATA_W-1:0] data_q, data_d;

  io_sel_decode #(.SEL_W(SEL_W), .DEV_CODE(DEV_CODE)) u_sel (
    .sel_bus(sel_bus), .hit(hit));

  io_cmd_decode u_cmd (
    .hit(hit), .cmd_valid(cmd_valid), .cmd(cmd), .stb(stb));

  io_parity_check #(.DATA_W(DATA_W)) u_par (
    .data(dev_rdata), .par(dev_rpar), .bad(par_bad));

  io_status_ctl u_stat (
    .clk(clk), .rst_n(rst_sync_n), .stb(stb), .dev_power(dev_power),
    .dev_done(dev_done), .par_bad(par_bad), .connected(connected),
    .busy(busy), .avail(avail), .code(code), .dir_wr(dev_dir),
    .start_pulse(dev_start), .view_status(view_status),
    .rd_capture(rd_capture));

  // data register: device capture, else processor write when idle
  always_comb begin
    data_d = data_q;
    if (rd_capture)                  data_d = dev_rdata;
    else if (hit && wr_en && !busy)  data_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) data_q <= '0;
    else             data_q <= data_d;
  end

  assign dev_wdata  = data_q;
  assign shown_code = dev_power ? code : CODE_W'(ST_PWROFF);

  // shared return path
  always_comb begin
    if (!hit)             rdata = '0;
    else if (view_status) rdata = {{PAD_W{1'b0}}, shown_code};
    else                  rdata = data_q;
  end

  // R7: writes while busy leave the register alone
  a_r7_busy_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && wr_en && !rd_capture) |=> $stable(data_q));
  // R1: a foreign code cannot change the connection
  a_r1_foreign_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!hit && dev_power) |=> $stable(connected));
  // R10: the direction holds while the operation runs
  a_r10_dir_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && $past(busy)) |-> $stable(dev_dir));
endmodule

// File: tb/sim_io_devctl.sv
`timescale 1ns/1ps
module sim_io_devctl;
  localparam int         SEL_W  = 6;
  localparam logic [5:0] CODE   = 6'h2B;
  localparam int         DATA_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cmd_valid, wr_en, dev_power, dev_done, dev_rpar;
  logic [SEL_W-1:0]  sel_bus;
  logic [2:0]        cmd;
  logic [DATA_W-1:0] wr_data, dev_rdata, rdata, dev_wdata;
  logic avail, dev_start, dev_dir;

  io_devctl #(.SEL_W(SEL_W), .DEV_CODE(CODE), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_bus(sel_bus), .cmd_valid(cmd_valid),
    .cmd(cmd), .wr_en(wr_en), .wr_data(wr_data), .rdata(rdata),
    .avail(avail), .dev_power(dev_power), .dev_done(dev_done),
    .dev_rdata(dev_rdata), .dev_rpar(dev_rpar), .dev_start(dev_start),
    .dev_dir(dev_dir), .dev_wdata(dev_wdata));

  int checks = 0;
  int fails  = 0;

  // bench model, built from the requirements
  logic       m_conn, m_busy, m_avail, m_dir, m_start, m_view;
  logic [2:0] m_code;
  logic [7:0] m_data;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    if (sel_bus != CODE) return 8'h00;
    if (m_view) return {5'b0, dev_power ? m_code : 3'd3};
    return m_data;
  endfunction

  function automatic logic odd9(input logic [7:0] d, input logic p);
    return ^{d, p};
  endfunction

  task automatic model_reset();
    m_conn = 0; m_busy = 0; m_avail = 1; m_dir = 0;
    m_start = 0; m_view = 0; m_code = 3'd2; m_data = 8'h00;
  endtask

  task automatic model_step();
    logic hit, c1, c2, cs, c5;
    logic busy_now;
    hit = (sel_bus == CODE);
    c1 = hit && cmd_valid && cmd == 3'd1;
    c2 = hit && cmd_valid && cmd == 3'd2;
    cs = hit && cmd_valid && (cmd == 3'd3 || cmd == 3'd4);
    c5 = hit && cmd_valid && cmd == 3'd5;
    busy_now = m_busy;
    m_start = 0;
    if (c5) m_view = 1;
    if (hit && wr_en && !busy_now) m_data = wr_data;
    if (!dev_power || c2) begin
      m_conn = 0; m_busy = 0; m_avail = 1; m_code = 3'd2;
    end else if (busy_now) begin
      if (dev_done) begin
        m_busy = 0; m_avail = 1;
        if (!m_dir) begin
          m_data = dev_rdata;
          m_code = odd9(dev_rdata, dev_rpar) ? 3'd5 : 3'd4;
        end else m_code = 3'd4;
      end
    end else if (c1) begin
      m_conn = 1; m_code = 3'd0;
    end else if (cs && m_conn) begin
      m_busy = 1; m_avail = 0; m_code = 3'd1; m_dir = (cmd == 3'd4);
      m_start = 1; m_view = 0;
    end
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R4 avail", {7'b0, avail}, {7'b0, m_avail});
    chk("R4 dev_start", {7'b0, dev_start}, {7'b0, m_start});
    chk("R9 rdata", rdata, exp_rdata());
    chk("R10 dev_wdata", dev_wdata, m_data);
    if (m_busy) chk("R10 dev_dir", {7'b0, dev_dir}, {7'b0, m_dir});
  endtask

  task automatic set_idle();
    sel_bus = CODE; cmd_valid = 0; cmd = 3'd0; wr_en = 0; wr_data = 8'h00;
    dev_done = 0; dev_rdata = 8'h00; dev_rpar = 0; dev_power = 1;
  endtask

  task automatic op(input logic [2:0] c);
    cmd_valid = 1; cmd = c; step(); set_idle();
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; step(); set_idle();
  endtask

  task automatic done_rd(input logic [7:0] d, input logic p);
    dev_done = 1; dev_rdata = d; dev_rpar = p; step(); set_idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    set_idle();
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 reset state
    chk("R2 avail", {7'b0, avail}, 8'd1);
    chk("R2 dev_start", {7'b0, dev_start}, 8'd0);
    chk("R2 rdata data view", rdata, 8'h00);
    op(3'd5);
    chk("R2 status disconnected", rdata, 8'd2);

    // R1 foreign code
    sel_bus = CODE ^ 6'h01; cmd_valid = 1; cmd = 3'd1; step(); set_idle();
    sel_bus = CODE ^ 6'h20; step();
    chk("R1 rdata unselected", rdata, 8'h00);
    set_idle();
    op(3'd5);
    chk("R1 no connect", rdata, 8'd2);

    // R3 connect / disconnect
    op(3'd1); op(3'd5);
    chk("R3 ready", rdata, 8'd0);
    op(3'd2); op(3'd5);
    chk("R3 disconnected", rdata, 8'd2);
    op(3'd7); op(3'd5);
    chk("R3 unused opcode", rdata, 8'd2);

    // R4 start ignored while disconnected
    op(3'd4);
    chk("R4 no start when disconnected", {7'b0, dev_start}, 8'd0);
    chk("R4 avail stays", {7'b0, avail}, 8'd1);
    op(3'd1);
    wr(8'h3C);
    chk("R10 wdata", dev_wdata, 8'h3C);

    // R4 accepted write start
    op(3'd4);
    chk("R4 avail low", {7'b0, avail}, 8'd0);
    chk("R4 start pulse", {7'b0, dev_start}, 8'd1);
    chk("R10 dir write", {7'b0, dev_dir}, 8'd1);
    step();
    chk("R4 pulse one cycle", {7'b0, dev_start}, 8'd0);
    op(3'd3);
    chk("R4 start ignored busy", {7'b0, dev_start}, 8'd0);

    // R7 write while busy
    wr(8'h99);
    chk("R7 data kept", dev_wdata, 8'h3C);
    op(3'd5);
    chk("R7 status busy", rdata, 8'd1);

    // R5 completion
    dev_done = 1; step(); set_idle();
    chk("R5 avail high", {7'b0, avail}, 8'd1);
    op(3'd5);
    chk("R5 completed", rdata, 8'd4);
    dev_done = 1; step(); set_idle();
    chk("R5 done idle no effect", rdata, 8'd4);

    // R6 read with good and bad parity
    op(3'd3);
    chk("R10 dir read", {7'b0, dev_dir}, 8'd0);
    done_rd(8'hA5, 1'b0);
    chk("R5 read captured", rdata, 8'hA5);
    op(3'd5);
    chk("R6 good parity", rdata, 8'd4);
    op(3'd3);
    done_rd(8'h07, 1'b0);
    chk("R6 bad byte captured", rdata, 8'h07);
    op(3'd5);
    chk("R6 parity error", rdata, 8'd5);
    op(3'd3);
    done_rd(8'h07, 1'b1);
    op(3'd5);
    chk("R6 parity bit fixes", rdata, 8'd4);

    // R8 power loss in mid operation
    op(3'd3);
    dev_power = 0; step();
    chk("R8 avail released", {7'b0, avail}, 8'd1);
    cmd_valid = 1; cmd = 3'd5; step();
    chk("R8 power off code", rdata, 8'd3);
    set_idle(); step();
    chk("R8 back to disconnected", rdata, 8'd2);
    op(3'd4);
    chk("R8 no start after power", {7'b0, dev_start}, 8'd0);

    // R9 return path switching
    op(3'd1);
    wr(8'h5A);
    chk("R9 status view", rdata, 8'd0);
    op(3'd4);
    chk("R9 data view after start", rdata, 8'h5A);
    dev_done = 1; step(); set_idle();

    // seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      sel_bus   = ($urandom % 5 != 0) ? CODE : 6'($urandom);
      cmd_valid = ($urandom % 5) < 2;
      cmd       = 3'($urandom);
      wr_en     = ($urandom % 4) == 0;
      wr_data   = 8'($urandom);
      dev_done  = ($urandom % 10) < 3;
      dev_rdata = 8'($urandom);
      dev_rpar  = (^dev_rdata) ^ (($urandom % 5) == 0);
      dev_power = ($urandom % 40) != 0;
      step();
    end
    set_idle();
    step();

    summary();
    $finish;
  end
endmodule